// File: doc/BRIEF.md
# Pipeline Operand Hazard Resolver

This block decides, for every source operand of the instruction sitting in the decode stage of a five-stage in-order pipeline, where that operand's value must come from and whether decode has to wait. It looks at the decode stage's source register numbers and read-enables. It compares them with the destination register, write-enable and load flag of the instructions now in execute, memory and writeback. The block is purely combinational. It settles in the same cycle in which the pipeline registers present their contents.

A compile-time switch selects one of two builds. The forwarding build routes a producer's result straight to the operand mux, taking the youngest producer first, and holds decode only when a load in execute feeds the very next instruction. The interlocked build has no forwarding path. Its select codes always name the register file, and it holds fetch and decode while any older instruction in execute, memory or writeback still has to write a register that decode reads. Whenever decode is held, the block also asks for a bubble to enter execute.

Top module: `hz_unit`

## Requirements
- R1: In the forwarding build, each operand's 2-bit select is 01 when the execute stage produces its register, otherwise 10 when memory produces it, otherwise 11 when writeback produces it, otherwise 00 (register file). The youngest producer wins.
- R2: A source register number of zero never produces a hazard: its select is 00 and it never causes a stall.
- R3: A producer matches a source only when that source's read-enable and the producer's write-enable are both 1 and the register numbers are equal. With read-enable 0 the select is 00.
- R4: In the forwarding build, stall is 1 exactly when some operand matches the execute-stage producer and that producer has its load flag set.
- R5: After a load-use hold, the load moves to memory and a bubble (write-enable 0) sits in execute. In that state stall is 0 and the dependent operand's select is 10, so the hold lasts one cycle.
- R6: In the interlocked build, every select is 00 under all inputs.
- R7: In the interlocked build, stall is 1 exactly when some operand matches a producer in execute, memory or writeback.
- R8: The bubble request into execute equals the fetch/decode hold in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_reg | input | NUM_SRC*REG_W | Decode-stage source register numbers, operand i in slice i |
| src_rd | input | NUM_SRC | Read-enable of each decode operand |
| ex_dst | input | REG_W | Destination register of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | REG_W | Destination register of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | REG_W | Destination register of the writeback-stage instruction |
| wb_wr | input | 1 | Writeback-stage instruction writes a register |
| fwd_sel | output | NUM_SRC*2 | Per-operand source select: 00 file, 01 execute, 10 memory, 11 writeback |
| hold_fd | output | 1 | Freeze fetch and decode this cycle |
| bubble_ex | output | 1 | Insert a bubble into execute this cycle |

## Verification
The bench builds the block twice with two source operands and a 2-bit register number, once forwarding and once interlocked. At that width every combination of register numbers, enables and the load flag fits in 65,536 vectors. The sweep therefore reaches all aliasing cases: both operands naming the same register, several stages writing the same register, and register zero in every position. The load-use case is also driven as a two-cycle sequence, the hold cycle followed by the cycle after the bubble.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int SEL_W   = 2;
  localparam int NUM_STG = 3;  // producers: execute, memory, writeback

  typedef enum logic [SEL_W-1:0] {
    FWD_RF  = 2'b00,
    FWD_EX  = 2'b01,
    FWD_MEM = 2'b10,
    FWD_WB  = 2'b11
  } fwd_sel_e;
endpackage

// File: rtl/hz_match.sv
module hz_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             src_en,
  input  logic [REG_W-1:0] dst,
  input  logic             dst_we,
  output logic             hit
);
  // register zero is hard-wired and never carries a dependence
  logic src_live;
  assign src_live = src_en && (src != '0);
  assign hit      = src_live && dst_we && (src == dst);
endmodule

// File: rtl/hz_operand.sv
module hz_operand
  import hz_pkg::*;
#(
  parameter int REG_W       = 5,
  parameter bit FULL_BYPASS = 1'b1
) (
  input  logic [REG_W-1:0]         src,
  input  logic                     src_en,
  input  logic [NUM_STG*REG_W-1:0] prod_dst,
  input  logic [NUM_STG-1:0]       prod_we,
  input  logic                     ex_load,
  output logic [SEL_W-1:0]         sel,
  output logic                     need_hold
);
  logic [NUM_STG-1:0] hit;

  for (genvar s = 0; s < NUM_STG; s++) begin : g_stg
    hz_match #(.REG_W(REG_W)) i_match (
      .src    (src),
      .src_en (src_en),
      .dst    (prod_dst[s*REG_W +: REG_W]),
      .dst_we (prod_we[s]),
      .hit    (hit[s])
    );
  end

  if (FULL_BYPASS) begin : g_byp
    fwd_sel_e pick;
    always_comb begin
      if (hit[0])      pick = FWD_EX;
      else if (hit[1]) pick = FWD_MEM;
      else if (hit[2]) pick = FWD_WB;
      else             pick = FWD_RF;
    end
    assign sel       = pick;
    // a load's data is not ready until it leaves memory
    assign need_hold = hit[0] && ex_load;
  end else begin : g_ilk
    logic unused_load;
    assign unused_load = ex_load;
    assign sel         = FWD_RF;
    assign need_hold   = |hit;
  end
endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int REG_W       = 5,
  parameter int NUM_SRC     = 2,
  parameter bit FULL_BYPASS = 1'b1
) (
  input  logic [NUM_SRC*REG_W-1:0] src_reg,
  input  logic [NUM_SRC-1:0]       src_rd,
  input  logic [REG_W-1:0]         ex_dst,
  input  logic                     ex_wr,
  input  logic                     ex_load,
  input  logic [REG_W-1:0]         mem_dst,
  input  logic                     mem_wr,
  input  logic [REG_W-1:0]         wb_dst,
  input  logic                     wb_wr,
  output logic [NUM_SRC*SEL_W-1:0] fwd_sel,
  output logic                     hold_fd,
  output logic                     bubble_ex
);
  logic [NUM_STG*REG_W-1:0] prod_dst;
  logic [NUM_STG-1:0]       prod_we;
  logic [NUM_SRC-1:0]       op_hold;

  // stage order sets forwarding priority: index 0 is the youngest
  assign prod_dst = {wb_dst, mem_dst, ex_dst};
  assign prod_we  = {wb_wr, mem_wr, ex_wr};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_op
    hz_operand #(.REG_W(REG_W), .FULL_BYPASS(FULL_BYPASS)) i_operand (
      .src       (src_reg[i*REG_W +: REG_W]),
      .src_en    (src_rd[i]),
      .prod_dst  (prod_dst),
      .prod_we   (prod_we),
      .ex_load   (ex_load),
      .sel       (fwd_sel[i*SEL_W +: SEL_W]),
      .need_hold (op_hold[i])
    );
  end

  assign hold_fd   = |op_hold;
  assign bubble_ex = hold_fd;
endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk #(
  parameter int REG_W       = 5,
  parameter int NUM_SRC     = 2,
  parameter bit FULL_BYPASS = 1'b1
) (
  input logic [NUM_SRC*REG_W-1:0] src_reg,
  input logic [NUM_SRC-1:0]       src_rd,
  input logic                     ex_load,
  input logic [NUM_SRC*2-1:0]     fwd_sel,
  input logic                     hold_fd,
  input logic                     bubble_ex
);
  always_comb begin
    // R8
    hold_bubble_agree_chk: assert (hold_fd == bubble_ex);
    for (int i = 0; i < NUM_SRC; i++) begin
      // R2
      zero_reg_file_chk: assert (src_reg[i*REG_W +: REG_W] != '0 || fwd_sel[i*2 +: 2] == 2'b00);
      // R3
      no_read_file_chk: assert (src_rd[i] || fwd_sel[i*2 +: 2] == 2'b00);
      // R6
      ilk_file_only_chk: assert (FULL_BYPASS || fwd_sel[i*2 +: 2] == 2'b00);
    end
  end

  logic any_ex_pick;
  always_comb begin
    any_ex_pick = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (fwd_sel[i*2 +: 2] == 2'b01) any_ex_pick = 1'b1;
  end

  always_comb begin
    // R4
    byp_hold_cause_chk: assert (!FULL_BYPASS || !hold_fd || (any_ex_pick && ex_load));
  end
endmodule

bind hz_unit hz_unit_chk #(
  .REG_W(REG_W), .NUM_SRC(NUM_SRC), .FULL_BYPASS(FULL_BYPASS)
) i_hz_unit_chk (
  .src_reg   (src_reg),
  .src_rd    (src_rd),
  .ex_load   (ex_load),
  .fwd_sel   (fwd_sel),
  .hold_fd   (hold_fd),
  .bubble_ex (bubble_ex)
);

// File: tb/test_hz_unit.sv
module test_hz_unit;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 2;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NS*RW-1:0] src_reg;
  logic [NS-1:0]    src_rd;
  logic [RW-1:0]    ex_dst, mem_dst, wb_dst;
  logic             ex_wr, ex_load, mem_wr, wb_wr;
  logic [NS*2-1:0]  sel_b, sel_i;
  logic             hold_b, hold_i, bub_b, bub_i;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  hz_unit #(.REG_W(RW), .NUM_SRC(NS), .FULL_BYPASS(1'b1)) i_hz_unit (
    .src_reg(src_reg), .src_rd(src_rd), .ex_dst(ex_dst), .ex_wr(ex_wr),
    .ex_load(ex_load), .mem_dst(mem_dst), .mem_wr(mem_wr), .wb_dst(wb_dst),
    .wb_wr(wb_wr), .fwd_sel(sel_b), .hold_fd(hold_b), .bubble_ex(bub_b));

  hz_unit #(.REG_W(RW), .NUM_SRC(NS), .FULL_BYPASS(1'b0)) i_hz_unit_ilk (
    .src_reg(src_reg), .src_rd(src_rd), .ex_dst(ex_dst), .ex_wr(ex_wr),
    .ex_load(ex_load), .mem_dst(mem_dst), .mem_wr(mem_wr), .wb_dst(wb_dst),
    .wb_wr(wb_wr), .fwd_sel(sel_i), .hold_fd(hold_i), .bubble_ex(bub_i));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (src=%h rd=%b ex=%0d/%0d/%0d mem=%0d/%0d wb=%0d/%0d)",
               req, act, exp, src_reg, src_rd, ex_dst, ex_wr, ex_load,
               mem_dst, mem_wr, wb_dst, wb_wr);
    end
  endtask

  // producer match: read and write enabled, nonzero, equal (R2, R3)
  function automatic bit dep(input int s, input bit en, input int d, input bit we);
    return en && we && (s != 0) && (s == d);
  endfunction

  task automatic drive(input int v);
    src_reg = v[3:0];
    src_rd  = v[5:4];
    ex_dst  = v[7:6];  ex_wr  = v[8]; ex_load = v[9];
    mem_dst = v[11:10]; mem_wr = v[12];
    wb_dst  = v[14:13]; wb_wr  = v[15];
  endtask

  task automatic judge();
    int exp_byp_hold = 0;
    int exp_ilk_hold = 0;
    for (int i = 0; i < NS; i++) begin
      int s = int'(src_reg[i*RW +: RW]);
      bit e = src_rd[i];
      bit he = dep(s, e, int'(ex_dst), ex_wr);
      bit hm = dep(s, e, int'(mem_dst), mem_wr);
      bit hw = dep(s, e, int'(wb_dst), wb_wr);
      int es = he ? 1 : hm ? 2 : hw ? 3 : 0;
      string tag = (s == 0) ? "R2" : (!e ? "R3" : "R1");
      check(tag, int'(sel_b[i*2 +: 2]), es);
      check("R6", int'(sel_i[i*2 +: 2]), 0);
      if (he && ex_load) exp_byp_hold = 1;
      if (he || hm || hw) exp_ilk_hold = 1;
    end
    check("R4", int'(hold_b), exp_byp_hold);
    check("R7", int'(hold_i), exp_ilk_hold);
    check("R8", int'(bub_b), int'(hold_b));
    check("R8", int'(bub_i), int'(hold_i));
  endtask

  initial begin
    drive(0);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle state after reset: nothing pending
    @(negedge clk);
    check("R1", int'(sel_b), 0);
    check("R4", int'(hold_b), 0);
    check("R7", int'(hold_i), 0);

    // R5: load in execute feeding operand 0 (x1), then one cycle later
    @(posedge clk); #1;
    drive(0);
    src_reg = 4'b0001; src_rd = 2'b01;
    ex_dst = 2'd1; ex_wr = 1'b1; ex_load = 1'b1;
    @(negedge clk);
    check("R5", int'(hold_b), 1);
    @(posedge clk); #1;
    mem_dst = 2'd1; mem_wr = 1'b1;
    ex_dst = 2'd0; ex_wr = 1'b0; ex_load = 1'b0;
    @(negedge clk);
    check("R5", int'(hold_b), 0);
    check("R5", int'(sel_b[1:0]), 2);

    // exhaustive sweep of both builds
    for (int v = 0; v < 65536; v++) begin
      @(posedge clk); #1;
      drive(v);
      @(negedge clk);
      judge();
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule